// File: doc/BRIEF.md
# Shadowed configuration register

This block holds one software-programmed configuration value behind a two-step write protocol. A bus write does not change the live value on its own. It only loads a staging register. A second write carrying the same data commits the value. A second write with different data is rejected and raises a one-cycle update-error alert. A bus read cancels any pending staged value, so that a stray half-finished update can never combine with a later write.

Each committed value is kept twice: once as written, and once bit-inverted in a redundant copy that sits on its own reset domain. A comparator checks at all times that the two copies are exact complements. If they ever diverge, for example from a fault or from a reset that reached only one domain, a fatal storage-error level is raised. It stays up until the main reset clears it with both copies back in agreement. While it is up, the register refuses all writes. Sticky status bits record that each kind of error has happened, for software to inspect.

Top module: `shadow_cfg_reg`

## Requirements
- R1: After both resets the committed value equals the RESET_VAL parameter, and update_err_o, storage_err_o, upd_err_sts_o and stor_err_sts_o are all 0.
- R2: A write with no staged value pending only stages the data, and q_o keeps its previous value.
- R3: A write that arrives while a value is staged and carries the same data commits it: q_o shows the data from the clock edge that samples that write.
- R4: A write that arrives while a value is staged and carries different data leaves q_o unchanged. It drives update_err_o high for exactly the one cycle after that edge, and it ends the pending update.
- R5: A read (rd_en_i) discards the staged value. A write in the same cycle as a read, or the next write after a read, counts as a first write and never raises an update error.
- R6: upd_err_sts_o is set by an update error and stays 1 until the main reset, including across later successful commits.
- R7: The redundant copy holds the bitwise inverse of the committed value. Whenever the two copies are not exact complements, storage_err_o is 1, and from the next edge stor_err_sts_o is 1. Both stay 1 until a main reset with the copies in agreement.
- R8: While storage_err_o is 1, writes are ignored: nothing is staged or committed, and no update error is raised.
- R9: If, after a value different from RESET_VAL has been committed, only rst_ni or only rst_shadow_ni is pulsed, storage_err_o rises. Pulsing both resets together returns the block to its R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Main asynchronous active-low reset (committed copy, staging, status) |
| rst_shadow_ni | input | 1 | Asynchronous active-low reset of the redundant copy |
| wr_en_i | input | 1 | Bus write strobe for this register |
| rd_en_i | input | 1 | Bus read strobe for this register |
| wdata_i | input | W | Write data |
| q_o | output | W | Committed value |
| update_err_o | output | 1 | One-cycle pulse on a mismatching second write |
| storage_err_o | output | 1 | Fatal level: the two copies disagree, or did since the last main reset |
| upd_err_sts_o | output | 1 | Sticky update-error status |
| stor_err_sts_o | output | 1 | Sticky storage-error status |

## Verification
The properties assume that rst_shadow_ni is never released while the main domain still holds state the bench has not yet observed. They also assume that a read and a write in the same cycle are legal bus behaviour, and that they act on a single register. All strobes and data change only on the falling clock edge. The bench asserts each reset for a whole cycle, so every property samples settled values. The exhaustive sweep covers every pair of 4-bit values for the two writes. Each pair is preceded by a read, so that every pair begins with no value staged.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  typedef enum logic {
    PH_IDLE   = 1'b0,
    PH_STAGED = 1'b1
  } phase_e;

  typedef struct packed {
    logic commit;
    logic reject;
  } wr_result_t;

endpackage

// File: rtl/shadow_cfg_stage.sv
module shadow_cfg_stage
  import shadow_cfg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic         block_i,
  input  logic [W-1:0] wdata_i,
  output logic         commit_o,
  output logic [W-1:0] commit_data_o,
  output logic         upd_err_o
);

  phase_e     phase_q, phase_d;
  logic [W-1:0] stage_q, stage_d;
  logic       upd_err_q;
  logic       wr_ok, staged_eff;
  wr_result_t res;

  // a read in the same cycle cancels the pending stage before the write is judged
  assign wr_ok      = wr_en_i & ~block_i;
  assign staged_eff = (phase_q == PH_STAGED) & ~rd_en_i;

  always_comb begin
    res.commit = wr_ok & staged_eff & (wdata_i == stage_q);
    res.reject = wr_ok & staged_eff & (wdata_i != stage_q);
  end

  always_comb begin
    phase_d = phase_q;
    stage_d = stage_q;
    if (rd_en_i) begin
      phase_d = PH_IDLE;
      stage_d = '0;
    end
    if (wr_ok) begin
      if (staged_eff) begin
        phase_d = PH_IDLE;
        stage_d = '0;
      end else begin
        phase_d = PH_STAGED;
        stage_d = wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      stage_q   <= '0;
      upd_err_q <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      stage_q   <= stage_d;
      upd_err_q <= res.reject;
    end
  end

  assign commit_o      = res.commit;
  assign commit_data_o = wdata_i;
  assign upd_err_o     = upd_err_q;

endmodule

// File: rtl/shadow_cfg_copies.sv
module shadow_cfg_copies #(
  parameter int         W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rst_shadow_ni,
  input  logic         commit_i,
  input  logic [W-1:0] commit_data_i,
  output logic [W-1:0] committed_o,
  output logic [W-1:0] shadow_o
);

  logic [W-1:0] committed_q, shadow_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       committed_q <= RESET_VAL;
    else if (commit_i) committed_q <= commit_data_i;
  end

  // redundant copy kept inverted, on its own reset domain
  always_ff @(posedge clk_i or negedge rst_shadow_ni) begin
    if (!rst_shadow_ni) shadow_q <= ~RESET_VAL;
    else if (commit_i)  shadow_q <= ~commit_data_i;
  end

  assign committed_o = committed_q;
  assign shadow_o    = shadow_q;

endmodule

// File: rtl/shadow_cfg_monitor.sv
module shadow_cfg_monitor #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] committed_i,
  input  logic [W-1:0] shadow_i,
  input  logic         upd_err_i,
  output logic         storage_err_o,
  output logic         upd_sts_o,
  output logic         stor_sts_o
);

  logic [W-1:0] diff;
  logic         mismatch;
  logic         stor_q, upd_q;

  // copies agree when every bit pair is complementary
  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign diff[i] = ~(committed_i[i] ^ shadow_i[i]);
  end
  assign mismatch = |diff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stor_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      stor_q <= stor_q | mismatch;
      upd_q  <= upd_q | upd_err_i;
    end
  end

  assign storage_err_o = stor_q | mismatch;
  assign stor_sts_o    = stor_q;
  assign upd_sts_o     = upd_q;

endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg #(
  parameter int           W         = 32,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rst_shadow_ni,
  input  logic         wr_en_i,
  input  logic         rd_en_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         update_err_o,
  output logic         storage_err_o,
  output logic         upd_err_sts_o,
  output logic         stor_err_sts_o
);

  logic         commit;
  logic [W-1:0] commit_data;
  logic [W-1:0] committed, shadow;
  logic         upd_err;
  logic         stor_err;

  shadow_cfg_stage #(.W(W)) u_stage (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .rd_en_i       (rd_en_i),
    .block_i       (stor_err),
    .wdata_i       (wdata_i),
    .commit_o      (commit),
    .commit_data_o (commit_data),
    .upd_err_o     (upd_err)
  );

  shadow_cfg_copies #(.W(W), .RESET_VAL(RESET_VAL)) u_copies (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_shadow_ni (rst_shadow_ni),
    .commit_i      (commit),
    .commit_data_i (commit_data),
    .committed_o   (committed),
    .shadow_o      (shadow)
  );

  shadow_cfg_monitor #(.W(W)) u_mon (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .committed_i   (committed),
    .shadow_i      (shadow),
    .upd_err_i     (upd_err),
    .storage_err_o (stor_err),
    .upd_sts_o     (upd_err_sts_o),
    .stor_sts_o    (stor_err_sts_o)
  );

  assign q_o           = committed;
  assign update_err_o  = upd_err;
  assign storage_err_o = stor_err;

endmodule

// File: rtl/shadow_cfg_reg_chk.sv
module shadow_cfg_reg_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic         rd_en_i,
  input logic [W-1:0] q_o,
  input logic         update_err_o,
  input logic         storage_err_o,
  input logic         upd_err_sts_o,
  input logic         stor_err_sts_o
);

  assert_q_moves_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(q_o) |-> ($past(wr_en_i) && !$past(rd_en_i) && !$past(storage_err_o)));

  assert_reject_keeps_q_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_err_o |-> $stable(q_o));

  assert_pulse_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_err_o |=> !update_err_o);

  assert_read_no_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> !update_err_o);

  assert_upd_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_err_sts_o |=> upd_err_sts_o);

  assert_upd_sets_sts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_err_o |=> upd_err_sts_o);

  assert_stor_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    storage_err_o |=> (storage_err_o && stor_err_sts_o));

  assert_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (storage_err_o && wr_en_i) |=> ($stable(q_o) && !update_err_o));

endmodule

bind shadow_cfg_reg shadow_cfg_reg_chk #(.W(W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .rd_en_i        (rd_en_i),
  .q_o            (q_o),
  .update_err_o   (update_err_o),
  .storage_err_o  (storage_err_o),
  .upd_err_sts_o  (upd_err_sts_o),
  .stor_err_sts_o (stor_err_sts_o)
);

// File: tb/sim_shadow_cfg_reg.sv
module sim_shadow_cfg_reg;
  localparam int           W        = 4;
  localparam logic [W-1:0] RST      = 4'h3;
  localparam int           CLK_P    = 10;
  localparam int           MAX_CYC  = 20000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rst_shadow_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] q_o;
  logic         update_err_o, storage_err_o, upd_err_sts_o, stor_err_sts_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] model_q;
  logic         model_sts;

  shadow_cfg_reg #(.W(W), .RESET_VAL(RST)) u0 (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] d);
    wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd();
    rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic rdwr(input logic [W-1:0] d);
    rd_en_i = 1'b1; wr_en_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
  endtask

  task automatic pulse_rst(input logic main, input logic shd);
    if (main) rst_ni = 1'b0;
    if (shd)  rst_shadow_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1; rst_shadow_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1; rst_shadow_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1", "q", q_o, RST);
    check("R1", "upd_err", update_err_o, 0);
    check("R1", "stor_err", storage_err_o, 0);
    check("R1", "upd_sts", upd_err_sts_o, 0);
    check("R1", "stor_sts", stor_err_sts_o, 0);
    model_q = RST; model_sts = 1'b0;

    // exhaustive pair sweep: R2, R3, R4, R6
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        rd();
        wr(W'(a));
        check("R2", "q after first write", q_o, model_q);
        wr(W'(b));
        if (a == b) model_q = W'(a);
        else model_sts = 1'b1;
        check("R3", "q after second write", q_o, model_q);
        check("R4", "upd_err pulse", update_err_o, (a != b) ? 1 : 0);
        @(negedge clk_i);
        check("R4", "upd_err falls", update_err_o, 0);
        check("R6", "upd_sts", upd_err_sts_o, model_sts);
      end
    end
    // last pair was 15,15 so a commit happened after errors: sticky still set
    check("R6", "sts kept over commit", upd_err_sts_o, 1);

    // R5 read discards stage
    rd();
    wr(4'h7);
    rd();
    wr(4'h9);
    check("R5", "no upd_err after read", update_err_o, 0);
    check("R5", "q held", q_o, 4'hF);
    wr(4'h9);
    check("R5", "commit after read", q_o, 4'h9);
    wr(4'h4);
    rdwr(4'h6);
    check("R5", "rd+wr is first write", update_err_o, 0);
    check("R5", "q held rd+wr", q_o, 4'h9);
    wr(4'h6);
    check("R5", "commit after rd+wr", q_o, 4'h6);
    check("R5", "no err after rd+wr", update_err_o, 0);

    // R7/R9 shadow reset only
    pulse_rst(1'b0, 1'b1);
    check("R9", "stor_err after shadow rst", storage_err_o, 1);
    check("R7", "stor_sts", stor_err_sts_o, 1);
    // R8 writes blocked
    wr(4'h5);
    wr(4'h5);
    check("R8", "q blocked", q_o, 4'h6);
    wr(4'h2);
    check("R8", "no upd_err blocked", update_err_o, 0);
    repeat (5) @(negedge clk_i);
    check("R7", "stor_err held", storage_err_o, 1);
    // main reset with copies now in agreement (both at reset value)
    pulse_rst(1'b1, 1'b0);
    check("R7", "cleared when copies agree", storage_err_o, 0);
    check("R7", "stor_sts cleared", stor_err_sts_o, 0);
    check("R6", "upd_sts cleared by main rst", upd_err_sts_o, 0);
    check("R1", "q after main rst", q_o, RST);

    // R9 main reset only
    wr(4'hA);
    wr(4'hA);
    check("R3", "commit A", q_o, 4'hA);
    pulse_rst(1'b1, 1'b0);
    check("R9", "stor_err after main rst", storage_err_o, 1);
    check("R7", "stor_sts after main rst", stor_err_sts_o, 1);
    wr(4'hC);
    wr(4'hC);
    check("R8", "q blocked again", q_o, RST);

    // R9 both resets
    pulse_rst(1'b1, 1'b1);
    check("R9", "stor_err clean", storage_err_o, 0);
    check("R9", "stor_sts clean", stor_err_sts_o, 0);
    check("R9", "q reset", q_o, RST);
    wr(4'hB);
    wr(4'hB);
    check("R3", "commit after recovery", q_o, 4'hB);

    summary();
    $finish;
  end

endmodule